// File: doc/BRIEF.md
# Bus Hold Arbiter

This block decides when a small processor's external bus may be handed to a second bus master. The other master raises a hold request. The arbiter never cuts a machine cycle short. It grants the bus at once if the core is idle. If a cycle is in flight, it grants the bus on the clock edge that sees that cycle's completion strobe. While the bus is granted it raises a hold acknowledge and pulls low every pad output enable of the address, data and control groups, so those pins float. The address latch strobe keeps its driver throughout.

The core keeps computing while the bus is away. Only new bus cycles are blocked: a stall output tells the core that no cycle may begin. A request the core makes during that time is remembered. It is launched as soon as ownership returns. Ownership returns one clock after the arbiter samples the hold request low. The remembered request starts on the clock after that.

Top module: `bus_hold_arbiter`

## Requirements
- R1: While reset is asserted, holdAck, busStall and cycleStart are 0 and every bit of addrEn, dataEn and ctrlEn is 1.
- R2: With no bus cycle in progress, a hold request sampled high at a clock edge sets holdAck to 1 after that same edge.
- R3: While a bus cycle is in progress, holdAck stays 0 until the edge that samples cycleDone high together with holdReq high; holdAck rises after that edge. A hold request withdrawn before cycleDone is never granted.
- R4: Whenever holdAck is 1, every bit of addrEn, dataEn and ctrlEn is 0.
- R5: latchEn is 1 at all times, including during reset and while holdAck is 1.
- R6: busStall is 1 whenever holdAck is 1, and cycleStart is never 1 while busStall is 1.
- R7: When the edge at which holdAck is first seen with holdReq low passes, holdAck stays 1 for exactly one more cycle. It then returns to 0 and all enables return to 1.
- R8: A one-cycle coreBusReq pulse given while holdAck is 1 is kept, not lost. It produces a cycleStart pulse in the cycle right after holdAck returns to 0.
- R9: A one-cycle coreBusReq pulse while the bus is owned and idle, with holdReq low, gives a cycleStart that is 1 for exactly one cycle, after the edge that samples the request.
- R10: If holdReq and coreBusReq are both sampled high at the same edge while idle, the hold wins. holdAck rises, no cycleStart is issued, and the core request is kept for after the release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| holdReq | input | 1 | Hold request from the other bus master |
| cycleDone | input | 1 | Strobe marking the last clock of the current machine cycle |
| coreBusReq | input | 1 | One-cycle pulse from the core asking for a new bus cycle |
| holdAck | output | 1 | Hold acknowledge: the bus is released to the other master |
| busStall | output | 1 | Tells the core that no new bus cycle may begin |
| cycleStart | output | 1 | One-cycle pulse launching a core bus cycle |
| addrEn | output | ADDR_W | Output enable per address pad |
| dataEn | output | DATA_W | Output enable per data pad |
| ctrlEn | output | CTRL_W | Output enable per control pad (read strobe, write strobe, space select) |
| latchEn | output | 1 | Output enable of the address latch strobe pad |

## Verification
The bench builds the arbiter with five address enables, three data enables and three control enables. These narrow groups let a single AND and OR reduction per group prove that every pad bit switches together with holdAck. The stimulus does four things. It grants a hold both in the middle of a cycle and while idle. It withdraws a request before the cycle ends. It makes the hold and a core request collide at the same edge. It also raises a core request during a hold, so that the exact cycle of the deferred launch after release can be checked.

// File: rtl/bus_hold_arbiter_pkg.sv
package bus_hold_arbiter_pkg;

  typedef enum logic [1:0] {
    BUS_OWN     = 2'd0,
    BUS_HELD    = 2'd1,
    BUS_RELEASE = 2'd2
  } busState_t;

  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic heldBus;  // bus given away (granted or in the release cycle)
    logic ownBus;   // core owns the bus and may start cycles
  } ctrlStrobes_t;

endpackage

// File: rtl/bus_hold_arbiter_ctrl.sv
module bus_hold_arbiter_ctrl
  import bus_hold_arbiter_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         holdReq,
  input  logic         cycleDone,
  input  logic         busy,
  output ctrlStrobes_t strobes
);

  busState_t state, stateNext;
  logic      atBoundary;

  // A grant is only legal between machine cycles
  assign atBoundary = !busy || cycleDone;

  always_comb begin
    stateNext = state;
    unique case (state)
      BUS_OWN:     if (holdReq && atBoundary) stateNext = BUS_HELD;
      BUS_HELD:    if (!holdReq) stateNext = BUS_RELEASE;
      BUS_RELEASE: stateNext = BUS_OWN;
      default:     stateNext = BUS_OWN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= BUS_OWN;
    else        state <= stateNext;
  end

  assign strobes.heldBus = (state != BUS_OWN);
  assign strobes.ownBus  = (state == BUS_OWN);

endmodule

// File: rtl/bus_hold_arbiter_datapath.sv
module bus_hold_arbiter_datapath
  import bus_hold_arbiter_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int CTRL_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctrlStrobes_t      strobes,
  input  logic              holdReq,
  input  logic              cycleDone,
  input  logic              coreBusReq,
  output logic              busy,
  output logic              cycleStart,
  output logic              busStall,
  output logic [ADDR_W-1:0] addrEn,
  output logic [DATA_W-1:0] dataEn,
  output logic [CTRL_W-1:0] ctrlEn,
  output logic              latchEn
);

  logic reqPending;
  logic reqAny;
  logic startNow;
  logic padDrive;

  assign reqAny   = coreBusReq || reqPending;
  assign startNow = strobes.ownBus && reqAny && (!busy || cycleDone) && !holdReq;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      reqPending <= 1'b0;
      cycleStart <= 1'b0;
    end else begin
      cycleStart <= startNow;
      reqPending <= reqAny && !startNow;
      if (startNow)       busy <= 1'b1;
      else if (cycleDone) busy <= 1'b0;
    end
  end

  assign busStall = strobes.heldBus;
  assign padDrive = !strobes.heldBus;

  // One enable per pad so each driver can be placed beside its pin
  for (genvar a = 0; a < ADDR_W; a++) begin : g_addr
    assign addrEn[a] = padDrive;
  end
  for (genvar d = 0; d < DATA_W; d++) begin : g_data
    assign dataEn[d] = padDrive;
  end
  for (genvar c = 0; c < CTRL_W; c++) begin : g_ctrl
    assign ctrlEn[c] = padDrive;
  end

  // Latch strobe is never floated
  assign latchEn = 1'b1;

endmodule

// File: rtl/bus_hold_arbiter.sv
module bus_hold_arbiter
  import bus_hold_arbiter_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int CTRL_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              holdReq,
  input  logic              cycleDone,
  input  logic              coreBusReq,
  output logic              holdAck,
  output logic              busStall,
  output logic              cycleStart,
  output logic [ADDR_W-1:0] addrEn,
  output logic [DATA_W-1:0] dataEn,
  output logic [CTRL_W-1:0] ctrlEn,
  output logic              latchEn
);

  ctrlStrobes_t strobes;
  logic         busy;

  bus_hold_arbiter_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .holdReq   (holdReq),
    .cycleDone (cycleDone),
    .busy      (busy),
    .strobes   (strobes)
  );

  bus_hold_arbiter_datapath #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .CTRL_W (CTRL_W)
  ) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobes    (strobes),
    .holdReq    (holdReq),
    .cycleDone  (cycleDone),
    .coreBusReq (coreBusReq),
    .busy       (busy),
    .cycleStart (cycleStart),
    .busStall   (busStall),
    .addrEn     (addrEn),
    .dataEn     (dataEn),
    .ctrlEn     (ctrlEn),
    .latchEn    (latchEn)
  );

  assign holdAck = strobes.heldBus;

endmodule

// File: rtl/bus_hold_arbiter_checker.sv
module bus_hold_arbiter_checker #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int CTRL_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              holdReq,
  input logic              cycleDone,
  input logic              holdAck,
  input logic              busStall,
  input logic              cycleStart,
  input logic [ADDR_W-1:0] addrEn,
  input logic [DATA_W-1:0] dataEn,
  input logic [CTRL_W-1:0] ctrlEn
);

  // Independent view of whether a machine cycle is in flight
  logic inCycle;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          inCycle <= 1'b0;
    else if (cycleStart) inCycle <= 1'b1;
    else if (cycleDone)  inCycle <= 1'b0;
  end

  assert_boundary_grant_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(holdAck) |-> $past(!inCycle || cycleDone));

  assert_pads_float_R4: assert property (@(posedge clk) disable iff (!rst_n)
    holdAck |-> (addrEn == '0 && dataEn == '0 && ctrlEn == '0));

  assert_no_start_when_stalled_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(busStall && cycleStart));

  assert_stall_with_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
    holdAck |-> busStall);

  assert_release_delay_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (holdAck && !holdReq && $past(holdReq)) |=> holdAck);

  assert_start_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cycleStart |=> !cycleStart);

endmodule

bind bus_hold_arbiter bus_hold_arbiter_checker #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .CTRL_W (CTRL_W)
) u_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .holdReq    (holdReq),
  .cycleDone  (cycleDone),
  .holdAck    (holdAck),
  .busStall   (busStall),
  .cycleStart (cycleStart),
  .addrEn     (addrEn),
  .dataEn     (dataEn),
  .ctrlEn     (ctrlEn)
);

// File: tb/bus_hold_arbiter_bench.sv
module bus_hold_arbiter_bench;

  localparam int ADDR_W = 5;
  localparam int DATA_W = 3;
  localparam int CTRL_W = 3;

  localparam int F_ACK   = 0;
  localparam int F_START = 1;
  localparam int F_STALL = 2;
  localparam int F_ALLEN = 3;
  localparam int F_ANYEN = 4;
  localparam int F_LATCH = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic holdReq = 1'b0;
  logic cycleDone = 1'b0;
  logic coreBusReq = 1'b0;
  logic holdAck, busStall, cycleStart, latchEn;
  logic [ADDR_W-1:0] addrEn;
  logic [DATA_W-1:0] dataEn;
  logic [CTRL_W-1:0] ctrlEn;

  always #2.5 clk = ~clk;  // 200 MHz

  bus_hold_arbiter #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .CTRL_W (CTRL_W)
  ) u_bus_hold_arbiter (
    .clk        (clk),
    .rst_n      (rst_n),
    .holdReq    (holdReq),
    .cycleDone  (cycleDone),
    .coreBusReq (coreBusReq),
    .holdAck    (holdAck),
    .busStall   (busStall),
    .cycleStart (cycleStart),
    .addrEn     (addrEn),
    .dataEn     (dataEn),
    .ctrlEn     (ctrlEn),
    .latchEn    (latchEn)
  );

  typedef struct {
    int    cyc;
    int    field;
    int    val;
    string tag;
  } expItem_t;

  expItem_t sb[$];
  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int getField(int f);
    case (f)
      F_ACK:   return int'(holdAck);
      F_START: return int'(cycleStart);
      F_STALL: return int'(busStall);
      F_ALLEN: return int'(&{addrEn, dataEn, ctrlEn});
      F_ANYEN: return int'(|{addrEn, dataEn, ctrlEn});
      F_LATCH: return int'(latchEn);
      default: return -1;
    endcase
  endfunction

  // Driver side: schedule an expected value dly cycles ahead
  task automatic expectAt(int dly, int field, int val, string tag);
    expItem_t it;
    it.cyc = cyc + dly;
    it.field = field;
    it.val = val;
    it.tag = tag;
    sb.push_back(it);
  endtask

  // Monitor: compare due items away from the active edge
  always @(negedge clk) begin
    for (int i = sb.size() - 1; i >= 0; i--) begin
      if (sb[i].cyc == cyc) begin
        int act;
        act = getField(sb[i].field);
        checks++;
        if (act != sb[i].val) begin
          errors++;
          $display("FAIL %s field=%0d cyc=%0d actual=%0d expected=%0d",
                   sb[i].tag, sb[i].field, cyc, act, sb[i].val);
        end
        sb.delete(i);
      end
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    step(2);
    // R1 / R5: reset state
    expectAt(1, F_ACK,   0, "R1");
    expectAt(1, F_ALLEN, 1, "R1");
    expectAt(1, F_STALL, 0, "R1");
    expectAt(1, F_START, 0, "R1");
    expectAt(1, F_LATCH, 1, "R5");
    step(1);
    rst_n = 1'b1;
    step(1);

    // R9: idle request launches a single-cycle start
    coreBusReq = 1'b1;
    expectAt(1, F_START, 1, "R9");
    expectAt(1, F_STALL, 0, "R9");
    step(1);
    coreBusReq = 1'b0;
    expectAt(1, F_START, 0, "R9");
    step(1);
    // R3: hold during a cycle waits for cycleDone
    holdReq = 1'b1;
    expectAt(1, F_ACK,   0, "R3");
    expectAt(1, F_ALLEN, 1, "R3");
    step(1);
    expectAt(1, F_ACK, 0, "R3");
    step(1);
    cycleDone = 1'b1;
    expectAt(1, F_ACK,   1, "R3");
    expectAt(1, F_ANYEN, 0, "R4");
    expectAt(1, F_LATCH, 1, "R5");
    expectAt(1, F_STALL, 1, "R6");
    step(1);
    // R8: request during hold is stalled and kept
    cycleDone = 1'b0;
    coreBusReq = 1'b1;
    expectAt(1, F_START, 0, "R6");
    expectAt(1, F_STALL, 1, "R6");
    step(1);
    coreBusReq = 1'b0;
    expectAt(1, F_START, 0, "R6");
    step(3);
    // R7: release one cycle after hold is seen low
    holdReq = 1'b0;
    expectAt(1, F_ACK,   1, "R7");
    expectAt(1, F_ANYEN, 0, "R7");
    expectAt(2, F_ACK,   0, "R7");
    expectAt(2, F_ALLEN, 1, "R7");
    expectAt(2, F_START, 0, "R8");
    expectAt(3, F_START, 1, "R8");
    expectAt(4, F_START, 0, "R8");
    step(4);
    cycleDone = 1'b1;
    step(1);
    cycleDone = 1'b0;
    step(1);

    // R2 / R10: idle hold and simultaneous core request
    holdReq = 1'b1;
    coreBusReq = 1'b1;
    expectAt(1, F_ACK,   1, "R2");
    expectAt(1, F_START, 0, "R10");
    step(1);
    coreBusReq = 1'b0;
    step(1);
    holdReq = 1'b0;
    expectAt(2, F_ACK,   0, "R7");
    expectAt(3, F_START, 1, "R10");
    step(5);
    cycleDone = 1'b1;
    step(1);
    cycleDone = 1'b0;
    step(1);

    // R3: hold withdrawn before the cycle ends is never granted
    coreBusReq = 1'b1;
    expectAt(1, F_START, 1, "R9");
    step(1);
    coreBusReq = 1'b0;
    holdReq = 1'b1;
    expectAt(1, F_ACK, 0, "R3");
    step(1);
    holdReq = 1'b0;
    expectAt(1, F_ACK, 0, "R3");
    step(1);
    cycleDone = 1'b1;
    expectAt(1, F_ACK,   0, "R3");
    expectAt(1, F_ALLEN, 1, "R3");
    step(1);
    cycleDone = 1'b0;
    expectAt(1, F_ACK, 0, "R3");
    step(3);

    if (sb.size() != 0) begin
      checks++;
      errors++;
      $display("FAIL scoreboard: actual=%0d expected=0 items left", sb.size());
    end
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule